// File: doc/BRIEF.md
# Run-In Lock Checker with Sample-Point Oscillator

This block produces the sample-point time base for a data-slicing receiver and decides whether a burst of run-in clock cycles at the start of a data line arrives at the expected rate. A 14-bit phase accumulator advances by a programmable step every clock and emits a one-cycle strobe each time it wraps. These strobes are the unit in which the duration of the run-in burst is measured.

The input is a bit stream that has already been compared against the slice level. While the run-in enable is high, the block waits for the first rising edge of that stream and then counts further rising edges until a programmed number has been reached. The number of strobes that occurred over that stretch is then compared against an inclusive window. If it falls inside the window, the block reports frequency lock and re-phases the accumulator on the next falling edge of the stream, so that later strobes land mid-bit. If it falls outside, the lock flag stays low and the surrounding sequencer can abandon the line.

Top module: `runin_dto_lock`

## Requirements
- R1: A 14-bit accumulator, cleared by reset, adds `phase_inc` modulo 2^14 on every clock; `sample_stb` is high for exactly the one cycle after the clock edge at which that addition carried out of bit 13.
- R2: While `rst_n` is low at a clock edge, `sample_stb`, `check_done` and `freq_lock` are all low after that edge.
- R3: A rising edge is a cycle in which `sliced_bit` is 1 and was 0 in the previous cycle; once `runin_en` has been high for one clock, the first rising edge starts the measurement with an elapsed count of zero.
- R4: The elapsed count is the number of strobes presented in the cycles after the first rising edge up to and including the cycle of the rising edge that brings the edge count to `runin_cycles`; a `runin_cycles` of 0 is treated as 1, giving an elapsed count of zero.
- R5: Lock is declared when `elapsed_lo` <= elapsed count <= `elapsed_hi` (both bounds inclusive, sampled in the cycle of the final rising edge); otherwise `freq_lock` stays low.
- R6: `check_done` is a one-cycle pulse in the cycle after the final rising edge, with `freq_lock` valid in that same cycle; `freq_lock` then holds until `runin_en` next rises, when it clears.
- R7: After a lock, the next falling edge (1 to 0) of `sliced_bit` loads the accumulator with 2^13; no strobe is issued for the cycle of that load even if the addition would have wrapped.
- R8: Without lock no re-phase occurs, and after the check any further rising or falling edges produce no second `check_done` and no further re-phase until `runin_en` has gone low.
- R9: If `runin_en` falls before the final rising edge, the measurement is abandoned and no `check_done` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sliced_bit | input | 1 | Data bit after slicing |
| runin_en | input | 1 | High while the run-in burst is expected |
| phase_inc | input | 14 | Accumulator step per clock |
| runin_cycles | input | 5 | Number of rising edges that end the measurement |
| elapsed_hi | input | 10 | Upper inclusive bound on elapsed strobes |
| elapsed_lo | input | 10 | Lower inclusive bound on elapsed strobes |
| sample_stb | output | 1 | One-cycle sample-point strobe |
| check_done | output | 1 | One-cycle pulse when the rate check ends |
| freq_lock | output | 1 | Rate check result, held until the next run-in |

## Verification
The two functions that can land on one cycle are the ordinary wrap of the accumulator and the re-phasing load triggered by the falling edge after a lock. The bench watches its own model of the accumulator and, in one burst, delays the falling edge until the model says the very next addition will carry, so the wrap and the load collide. The strobe output is compared with the model every cycle, and in that collision the model expects no strobe and a mid-range restart, so a design that lets the wrap through or skips the load shows up as a strobe mismatch in the following cycles.

// File: rtl/rdl_pkg.sv
// Shared types for the run-in lock checker.
package rdl_pkg;
    // Measurement sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_MEAS = 3'd2,
        ST_FALL = 3'd3,
        ST_HOLD = 3'd4
    } meter_st_e;
endpackage

// File: rtl/rdl_dto.sv
// Phase accumulator producing sample-point strobes.
// Adds inc_i every clock; the carry out, registered, is the strobe.
// A re-phase request loads half range and suppresses that cycle's strobe.
// Assumes inc_i is held stable while a run-in is being measured.
module rdl_dto #(
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             rephase_i,
    output logic             stb_o
);
    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q;
    logic             stb_q;
    logic [ACC_W:0]   sum;

    // Next accumulator value with carry.
    assign sum = {1'b0, acc_q} + {1'b0, inc_i};

    // Advance or re-phase the accumulator and register the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            stb_q <= 1'b0;
        end else if (rephase_i) begin
            acc_q <= HALF;
            stb_q <= 1'b0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
            stb_q <= sum[ACC_W];
        end
    end

    assign stb_o = stb_q;

    // R1
    wrap_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (acc_q < $past(inc_i)));

    // R7
    rephase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rephase_i |=> (acc_q == HALF && !stb_q));
endmodule

// File: rtl/rdl_edges.sv
// Edge detector on the sliced bit stream.
// Compares the current bit with the value registered one clock earlier.
// Assumes the bit is already synchronous to clk.
module rdl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Hold the previous-cycle bit value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= bit_i;
    end

    assign rise_o = bit_i & ~prev_q;
    assign fall_o = ~bit_i & prev_q;
endmodule

// File: rtl/rdl_meter.sv
// Run-in rate meter: counts rising edges, measures elapsed strobes from the
// first edge, compares the total with an inclusive window, raises a one-cycle
// done pulse with the lock result and requests a re-phase on the next falling
// edge after a lock. Assumes bounds are valid in the final-edge cycle.
module rdl_meter
    import rdl_pkg::*;
#(
    parameter int EDGE_W = 5,
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              stb_i,
    input  logic [EDGE_W-1:0] tgt_i,
    input  logic [TIME_W-1:0] lo_i,
    input  logic [TIME_W-1:0] hi_i,
    output logic              done_o,
    output logic              lock_o,
    output logic              rephase_o
);
    meter_st_e         state_q, state_d;
    logic [EDGE_W-1:0] cnt_q, cnt_d;
    logic [TIME_W-1:0] elap_q, elap_d;
    logic              done_q, done_d;
    logic              lock_q, lock_d;

    logic [EDGE_W-1:0] tgt_eff;
    logic [EDGE_W:0]   cnt_plus;
    logic              last_edge;
    logic [TIME_W-1:0] elap_inc;
    logic [TIME_W-1:0] meas;
    logic              in_rng;

    // Effective target, zero counts as one edge.
    assign tgt_eff   = (tgt_i == '0) ? EDGE_W'(1) : tgt_i;
    assign cnt_plus  = {1'b0, cnt_q} + (EDGE_W+1)'(1);
    assign last_edge = (cnt_plus == {1'b0, tgt_eff});

    // Saturating elapsed count including this cycle's strobe.
    assign elap_inc = (stb_i && !(&elap_q)) ? elap_q + TIME_W'(1) : elap_q;
    assign meas     = (state_q == ST_ARM) ? '0 : elap_inc;
    assign in_rng   = (meas >= lo_i) && (meas <= hi_i);

    // Sequencer next-state and datapath decisions.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        elap_d    = elap_q;
        done_d    = 1'b0;
        lock_d    = lock_q;
        rephase_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    state_d = ST_ARM;
                    lock_d  = 1'b0;
                end
            end
            ST_ARM: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (rise_i) begin
                    if (tgt_eff == EDGE_W'(1)) begin
                        done_d  = 1'b1;
                        lock_d  = in_rng;
                        state_d = in_rng ? ST_FALL : ST_HOLD;
                    end else begin
                        state_d = ST_MEAS;
                        cnt_d   = EDGE_W'(1);
                        elap_d  = '0;
                    end
                end
            end
            ST_MEAS: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else begin
                    elap_d = elap_inc;
                    if (rise_i) begin
                        if (last_edge) begin
                            done_d  = 1'b1;
                            lock_d  = in_rng;
                            state_d = in_rng ? ST_FALL : ST_HOLD;
                        end else begin
                            cnt_d = cnt_plus[EDGE_W-1:0];
                        end
                    end
                end
            end
            ST_FALL: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (fall_i) begin
                    rephase_o = 1'b1;
                    state_d   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!en_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register sequencer state, counters and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            elap_q  <= '0;
            done_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            elap_q  <= elap_d;
            done_q  <= done_d;
            lock_q  <= lock_d;
        end
    end

    assign done_o = done_q;
    assign lock_o = lock_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> done_q);

    // R9
    done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(en_i));

    // R8
    rephase_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rephase_o |-> (lock_q && !done_q));
endmodule

// File: rtl/runin_dto_lock.sv
// Top level: sample-point oscillator plus run-in rate check.
// Ties the edge detector, the rate meter and the phase accumulator together;
// the meter's strobe input is the accumulator's registered strobe.
// Assumes sliced_bit and runin_en are synchronous to clk.
module runin_dto_lock #(
    parameter int ACC_W  = 14,
    parameter int EDGE_W = 5,
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sliced_bit,
    input  logic              runin_en,
    input  logic [ACC_W-1:0]  phase_inc,
    input  logic [EDGE_W-1:0] runin_cycles,
    input  logic [TIME_W-1:0] elapsed_hi,
    input  logic [TIME_W-1:0] elapsed_lo,
    output logic              sample_stb,
    output logic              check_done,
    output logic              freq_lock
);
    logic rise, fall, rephase, stb;

    rdl_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (sliced_bit),
        .rise_o (rise),
        .fall_o (fall)
    );

    rdl_meter #(.EDGE_W(EDGE_W), .TIME_W(TIME_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (runin_en),
        .rise_i    (rise),
        .fall_i    (fall),
        .stb_i     (stb),
        .tgt_i     (runin_cycles),
        .lo_i      (elapsed_lo),
        .hi_i      (elapsed_hi),
        .done_o    (check_done),
        .lock_o    (freq_lock),
        .rephase_o (rephase)
    );

    rdl_dto #(.ACC_W(ACC_W)) u_dto (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (phase_inc),
        .rephase_i (rephase),
        .stb_o     (stb)
    );

    assign sample_stb = stb;
endmodule

// File: tb/runin_dto_lock_tb.sv
module runin_dto_lock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sliced_bit = 1'b0;
    logic       runin_en = 1'b0;
    logic [13:0] phase_inc = 14'd4096;
    logic [4:0]  runin_cycles = 5'd7;
    logic [9:0]  elapsed_hi = 10'd0;
    logic [9:0]  elapsed_lo = 10'd0;
    logic       sample_stb, check_done, freq_lock;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference accumulator model (R1, R7)
    int ref_acc = 0;
    bit ref_stb = 1'b0;
    int reph_req = 0;
    int reph_ack = 0;

    // expected lock results, one per check_done pulse
    bit exp_q[$];
    bit exp_flag = 1'b0;
    int e_cnt = 0;
    bit counting = 1'b0;

    always #4 clk = ~clk;

    runin_dto_lock dut_i (
        .clk(clk), .rst_n(rst_n), .sliced_bit(sliced_bit), .runin_en(runin_en),
        .phase_inc(phase_inc), .runin_cycles(runin_cycles),
        .elapsed_hi(elapsed_hi), .elapsed_lo(elapsed_lo),
        .sample_stb(sample_stb), .check_done(check_done), .freq_lock(freq_lock)
    );

    // model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_acc = 0;
            ref_stb = 1'b0;
        end else if (reph_req != reph_ack) begin
            reph_ack = reph_ack + 1;
            ref_acc  = 8192;
            ref_stb  = 1'b0;
        end else begin
            ref_acc = ref_acc + int'(phase_inc);
            ref_stb = (ref_acc >= 16384);
            if (ref_acc >= 16384) ref_acc = ref_acc - 16384;
        end
    end

    // monitor: strobe compare and scoreboard pop
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (sample_stb !== ref_stb) begin
                fails++;
                $display("FAIL R1/R7 sample_stb actual=%0b expected=%0b t=%0t",
                         sample_stb, ref_stb, $time);
            end
            if (check_done === 1'b1) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8/R9 check_done actual=1 expected=0 t=%0t", $time);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (freq_lock !== e) begin
                        fails++;
                        $display("FAIL R5 freq_lock actual=%0b expected=%0b t=%0t",
                                 freq_lock, e, $time);
                    end
                end
            end
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (counting) e_cnt = e_cnt + int'(ref_stb);
    endtask

    // one run-in burst; dlo/dhi offsets from measured elapsed count
    task automatic burst(input int half, input int nedge, input int tgt,
                         input int dlo, input int dhi, input bit coincide,
                         input int abort_after);
        int lo, hi;
        bit exp_lock;
        runin_cycles = 5'(tgt);
        sliced_bit = 1'b0;
        runin_en = 1'b1;
        repeat (3) tick();
        // R6: lock flag cleared at the start of a new run-in
        check1("R6 lock cleared at start", freq_lock, 1'b0);
        e_cnt = 0;
        counting = 1'b0;
        exp_lock = 1'b0;
        for (int k = 1; k <= nedge; k++) begin
            if (k > 1) repeat (half) tick();
            if (k == nedge) begin
                lo = e_cnt + dlo; if (lo < 0) lo = 0;
                hi = e_cnt + dhi; if (hi < 0) hi = 0;
                elapsed_lo = 10'(lo);
                elapsed_hi = 10'(hi);
                exp_lock = (e_cnt >= lo) && (e_cnt <= hi);
                exp_q.push_back(exp_lock);
            end
            sliced_bit = 1'b1;
            counting = 1'b1;
            if (k == nedge) counting = 1'b0;
            if (abort_after == k) begin
                // R9: drop enable before the final edge
                repeat (half) tick();
                counting = 1'b0;
                runin_en = 1'b0;
                sliced_bit = 1'b0;
                repeat (4) tick();
                check1("R9 no lock after abort", freq_lock, 1'b0);
                exp_flag = 1'b0;
                return;
            end
            if (k < nedge) begin
                repeat (half) tick();
                sliced_bit = 1'b0;
            end
        end
        repeat (half) tick();
        if (exp_lock && coincide) begin
            // R7: make the re-phase land on a wrapping cycle
            while (ref_acc + int'(phase_inc) < 16384) tick();
        end
        sliced_bit = 1'b0;
        if (exp_lock) reph_req = reph_req + 1;
        exp_flag = exp_lock;
        repeat (half) tick();
        // R8: further edges after the check
        repeat (2) begin
            sliced_bit = 1'b1;
            repeat (half) tick();
            sliced_bit = 1'b0;
            repeat (half) tick();
        end
        // R6: lock flag holds after the check
        check1("R6 lock held", freq_lock, exp_flag);
        runin_en = 1'b0;
        repeat (3) tick();
        check1("R6 lock held after enable drop", freq_lock, exp_flag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R2: outputs low under reset
        check1("R2 sample_stb in reset", sample_stb, 1'b0);
        check1("R2 check_done in reset", check_done, 1'b0);
        check1("R2 freq_lock in reset", freq_lock, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: free-running strobes
        repeat (40) tick();
        // R3 R4 R5 R7: in-range lock with wrap/re-phase collision
        burst(4, 7, 7, -1, 1, 1'b1, 0);
        // R5: exact inclusive bounds
        burst(4, 7, 7, 0, 0, 1'b0, 0);
        // R5 R8: lower bound above count, no lock
        burst(4, 7, 7, 1, 3, 1'b0, 0);
        // R5 R8: upper bound below count, no lock
        burst(3, 6, 6, -3, -1, 1'b0, 0);
        // R4: target zero acts as one edge
        burst(5, 1, 0, 0, 0, 1'b1, 0);
        // R9: abandoned measurement
        burst(4, 5, 5, -2, 2, 1'b0, 3);
        // R1 R7: odd step size
        phase_inc = 14'd3001;
        repeat (10) tick();
        burst(5, 9, 9, -1, 2, 1'b1, 0);
        burst(2, 4, 4, 0, 0, 1'b0, 0);
        repeat (20) tick();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 missing check_done actual=%0d expected=0 pending", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule